// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block runs ahead of an execution stage and keeps a small buffer of upcoming instruction bytes, so that the consumer finds its next byte already on hand instead of waiting for memory. It owns a 20-bit byte fetch pointer. Whenever there is room in the buffer, it asks memory for more bytes over a 16-bit data path. The width of each fetch follows the parity of the pointer. From an even address a whole word arrives in one bus operation. From an odd address only the odd byte arrives, after which the pointer is even and later fetches are full words.

The consumer sees a valid flag and the oldest byte, and takes that byte by raising `pop_en`. A flush input empties the buffer and reloads the fetch pointer, for example after a taken branch. If a fetch was still in flight when the flush arrived, its data is discarded when it returns.

The fetch side is a three-state machine. `FS_IDLE` issues a one-cycle request when there is room and moves to `FS_WAIT`. `FS_WAIT` leaves for `FS_IDLE` on an acknowledge. A flush in `FS_WAIT` without an acknowledge moves it to `FS_DROP`. A flush in `FS_WAIT` with an acknowledge in the same cycle moves it to `FS_IDLE` and drops the data. `FS_DROP` returns to `FS_IDLE` on the acknowledge of the abandoned fetch.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the buffer is empty (`pop_valid` = 0), the fetch pointer equals parameter `RESET_ADDR` (default 0), and no fetch is outstanding.
- R2: A fetch from an even pointer drives `mem_word` = 1 and `mem_addr` = pointer. On acknowledge, `mem_rdata[7:0]` is queued first and `mem_rdata[15:8]` second, and the pointer advances by 2.
- R3: A fetch from an odd pointer drives `mem_word` = 0. On acknowledge, only `mem_rdata[15:8]` is queued and the pointer advances by 1, which makes it even.
- R4: `mem_req` is a one-cycle pulse, raised only while no fetch is outstanding and no flush is present, and only when the free space is at least 2 bytes (even pointer) or 1 byte (odd pointer).
- R5: The buffer never holds more than 6 bytes. When it is full, no request is issued.
- R6: `pop_valid` is high exactly when the buffer is non-empty, and `pop_byte` is then its oldest byte. A pop while the buffer is empty has no effect.
- R7: A pop and an acknowledged fetch in the same cycle both take effect, with no byte lost or duplicated.
- R8: A flush empties the buffer, loads `flush_addr` into the pointer and suppresses any request in that cycle. A pop in the same cycle is ignored.
- R9: Data of a fetch that was outstanding at a flush, including one acknowledged in the flush cycle, never enters the buffer. No new request is issued until that fetch has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty buffer and reload pointer |
| flush_addr | input | 20 | New fetch pointer on flush |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 20 | Byte address of the fetch |
| mem_word | output | 1 | 1 = word fetch, 0 = odd byte fetch |
| mem_ack | input | 1 | Fetch completion; data valid this cycle |
| mem_rdata | input | 16 | Fetched data, even byte in [7:0] |
| pop_en | input | 1 | Consumer takes the front byte |
| pop_valid | output | 1 | Buffer non-empty |
| pop_byte | output | 8 | Oldest buffered byte |

## Verification
Several events can fall in the same cycle: a consumer pop and the arrival of fetched bytes, and a flush with either of them. The bench provokes these coincidences with random pops, acknowledges and flushes at several densities, including a phase that flushes often while a fetch is outstanding. A behavioural byte queue in the bench predicts `pop_valid`, `pop_byte`, `mem_req`, `mem_addr` and `mem_word` on every clock. A lost, duplicated or stray byte therefore shows up as a data mismatch at a later pop.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          valid,
    output logic [7:0]    front
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    slots [DEPTH];
    logic [IW-1:0] rd_ix, wr_ix;
    logic          pop_ok;

    function automatic logic [IW-1:0] step_ix(input logic [IW-1:0] ix, input int n);
        int s;
        s = int'(ix) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    assign valid  = (count != '0);
    assign front  = slots[rd_ix];
    assign pop_ok = pop && valid && !clear;

    always_ff @(posedge clk) begin
        if (!clear && push_n != 2'd0) slots[wr_ix] <= push_b0;
        if (!clear && push_n == 2'd2) slots[step_ix(wr_ix, 1)] <= push_b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ix <= '0;
            wr_ix <= '0;
            count <= '0;
        end else begin
            wr_ix <= step_ix(wr_ix, int'(push_n));
            if (pop_ok) rd_ix <= step_ix(rd_ix, 1);
            count <= count + CW'(push_n) - CW'(pop_ok);
        end
    end

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R5
    AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && pop && push_n == 2'd0) |=> (count == '0)); // R6
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int              AW         = 20,
    parameter int              DEPTH      = 6,
    parameter int              CW         = $clog2(DEPTH + 1),
    parameter logic [AW-1:0]   RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          mem_ack,
    input  logic [15:0]   mem_rdata,
    input  logic [CW-1:0] count,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_word,
    output logic [1:0]    push_n,
    output logic [7:0]    push_b0,
    output logic [7:0]    push_b1
);
    fetch_state_t  state, nxt;
    logic [AW-1:0] ptr;
    logic [CW-1:0] free_n, need_n;
    logic          room;

    assign free_n = CW'(DEPTH) - count;
    assign need_n = ptr[0] ? CW'(1) : CW'(2);
    assign room   = (free_n >= need_n);

    // state register and fetch pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            ptr   <= RESET_ADDR;
        end else begin
            state <= nxt;
            if (flush)
                ptr <= flush_addr;
            else if (state == FS_WAIT && mem_ack)
                ptr <= ptr + (ptr[0] ? AW'(1) : AW'(2));
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE: if (!flush && room) nxt = FS_WAIT;
            FS_WAIT: begin
                if (flush)        nxt = mem_ack ? FS_IDLE : FS_DROP;
                else if (mem_ack) nxt = FS_IDLE;
            end
            FS_DROP: if (mem_ack) nxt = FS_IDLE;
            default: nxt = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        push_n   = 2'd0;
        mem_addr = ptr;
        mem_word = !ptr[0];
        push_b0  = ptr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
        push_b1  = mem_rdata[15:8];
        unique case (state)
            FS_IDLE: mem_req = !flush && room;
            FS_WAIT: if (mem_ack && !flush) push_n = ptr[0] ? 2'd1 : 2'd2;
            FS_DROP: push_n = 2'd0;
            default: mem_req = 1'b0;
        endcase
    end

    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (int'(count) + (mem_word ? 2 : 1) <= DEPTH)); // R4
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R4
    AST_ODD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr[0]) |-> !mem_word); // R3
    AST_DROP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_DROP) |-> (push_n == 2'd0 && !mem_req)); // R9
    AST_FLUSH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !mem_req); // R8
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int            AW         = 20,
    parameter int            DEPTH      = 6,
    parameter logic [19:0]   RESET_ADDR = 20'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_word,
    input  logic          mem_ack,
    input  logic [15:0]   mem_rdata,
    input  logic          pop_en,
    output logic          pop_valid,
    output logic [7:0]    pop_byte
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [1:0]    push_n;
    logic [7:0]    push_b0, push_b1;

    pfq_fetch #(
        .AW(AW), .DEPTH(DEPTH), .CW(CW), .RESET_ADDR(AW'(RESET_ADDR))
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .count(count),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
    );

    pfq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop(pop_en), .count(count), .valid(pop_valid), .front(pop_byte)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pop_valid); // R8
endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] flush_addr = '0;
    logic        mem_req, mem_word, pop_valid;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        pop_en = 1'b0;
    logic [7:0]  pop_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    prefetch_queue uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pop_en(pop_en), .pop_valid(pop_valid), .pop_byte(pop_byte)
    );

    // behavioural reference
    logic [7:0]  q[$];
    logic [19:0] mptr;
    int          st;          // 0 idle, 1 waiting, 2 dropping
    string       prev_tag;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5} ^ 8'h3C;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic one_cycle(input int pop_pct, input int flush_pct, input int ack_pct);
        logic exp_req, popped, fl, pp, ak;
        logic [19:0] fa;
        fl = ($urandom_range(99) < flush_pct);
        fa = 20'($urandom);
        pp = ($urandom_range(99) < pop_pct);
        ak = (st != 0) && ($urandom_range(99) < ack_pct);
        flush = fl; flush_addr = fa; pop_en = pp; mem_ack = ak;
        if (mptr[0]) mem_rdata = {mem_byte(mptr), 8'($urandom)};
        else         mem_rdata = {mem_byte(mptr + 20'd1), mem_byte(mptr)};
        if (st == 2) mem_rdata = 16'($urandom);
        #1;
        // R6/R7/R8 visible queue contents
        check({prev_tag, " pop_valid"}, 32'(pop_valid), 32'(q.size() > 0));
        if (q.size() > 0) check({prev_tag, " pop_byte"}, 32'(pop_byte), 32'(q[0]));
        exp_req = (st == 0) && !fl && ((6 - q.size()) >= (mptr[0] ? 1 : 2));
        check(st == 2 ? "R9 req during drop" : fl ? "R8 req on flush" :
              q.size() == 6 ? "R5 req when full" : "R4 mem_req",
              32'(mem_req), 32'(exp_req));
        if (exp_req) begin
            check(mptr[0] ? "R3 mem_addr" : "R2 mem_addr", 32'(mem_addr), 32'(mptr));
            check(mptr[0] ? "R3 mem_word" : "R2 mem_word", 32'(mem_word), 32'(!mptr[0]));
        end
        @(posedge clk);
        popped = pp && (q.size() > 0) && !fl;
        prev_tag = "R6";
        if (popped) void'(q.pop_front());
        if (fl) begin
            q.delete();
            if (st != 0) st = ak ? 0 : 2;
            mptr = fa;
            prev_tag = "R8";
        end else begin
            case (st)
                0: if (exp_req) st = 1;
                1: if (ak) begin
                    if (mptr[0]) begin
                        q.push_back(mem_byte(mptr));
                        mptr = mptr + 20'd1;
                    end else begin
                        q.push_back(mem_byte(mptr));
                        q.push_back(mem_byte(mptr + 20'd1));
                        mptr = mptr + 20'd2;
                    end
                    st = 0;
                    if (popped) prev_tag = "R7";
                end
                default: if (ak) st = 0;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7));
        mptr = 20'h0; st = 0; prev_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pop_valid after reset", 32'(pop_valid), 32'd0);
        check("R1 mem_addr after reset", 32'(mem_addr), 32'h0);
        check("R1 first request", 32'(mem_req), 32'd1);
        @(negedge clk);
        st = 1;
        // fill without pops to reach capacity
        for (int i = 0; i < 400; i++) one_cycle(0, 0, 60);
        check("R5 full buffer holds six", 32'(q.size()), 32'd6);
        for (int i = 0; i < 3000; i++) one_cycle(50, 2, 50);
        for (int i = 0; i < 3000; i++) one_cycle(90, 5, 80);
        for (int i = 0; i < 3000; i++) one_cycle(20, 30, 50);
        for (int i = 0; i < 3000; i++) one_cycle(70, 1, 20);
        for (int i = 0; i < 2000; i++) one_cycle(100, 10, 100);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule